// File: doc/BRIEF.md
# Hierarchical Telemetry Frame Commutator

This block builds a telemetry stream out of measurements taken at four nested sampling rates, called decks. It shifts out 7-bit words one bit per strobe, most significant bit first. The words are grouped into minor frames of 32 word slots, and each minor frame opens with a fixed sync pattern. The remaining slots follow a fixed slot map. Most of them serve the fastest deck. The three slower decks get one slot each per minor frame, and their position counters step more slowly. One full pass of the slowest deck makes a major frame.

For every data slot, the block puts a channel address on `chan_addr` and raises `addr_valid`. The measurement front end answers on `meas_data` in the same cycle. The word is captured on the strobe that sends its first bit. A bit-rate strobe input `bit_stb` sets the pace, so the same logic serves a 1000 bit/s stream or one at 33 1/3 or 8 1/3 bit/s. The two frame markers travel beside the serial bit, so a receiver can align to minor and major frames.

With the default parameters, the fastest deck has 28 positions and each is sampled 128 times per major frame. The second deck has 8 positions, sampled 16 times each. The third deck has 64 positions, sampled twice each. The slowest deck has 128 positions, sampled once each. A major frame is therefore 128 minor frames long. These decks use 228 of the 256 locations the 8-bit address can reach.

Top module: `tlm_commutator`

## Requirements
- R1: While reset is high and after it is released, before any strobe: `ser_out`, `minor_mark` and `major_mark` are 0, `addr_valid` is 0 and `chan_addr` is 0.
- R2: Each word is 7 bits and leaves on `ser_out` MSB first, one bit per strobe. `ser_out` changes on the clock edge that samples `bit_stb` high. A data word holds the value of `meas_data` on the strobe that sends its first bit.
- R3: Word slot 0 of every minor frame carries the sync pattern 7'b1110010.
- R4: A minor frame is 32 words long. `minor_mark` is 1 exactly while `ser_out` holds the first bit of slot 0.
- R5: Slot map: slots 1..28 serve deck 0, slot 29 serves deck 1, slot 30 serves deck 2 and slot 31 serves deck 3. The address is the deck base plus the deck position. The bases are 0, 28, 36 and 100.
- R6: A deck position advances by one only at the end of a slot that serves that deck. The positions wrap at the deck sizes 28, 8, 64 and 128.
- R7: Over one major frame (128 minor frames), every address 0..27 is served 128 times, 28..35 16 times, 36..99 twice and 100..227 once. Addresses 228..255 are never served.
- R8: `major_mark` is 1 exactly while `ser_out` holds the first bit of slot 0 of minor frame 0, and it implies `minor_mark`. All deck positions are zero at that point.
- R9: In a cycle without a strobe, `ser_out`, the markers and `chan_addr` keep their values.
- R10: `addr_valid` is 0 during slot 0 and 1 during every data slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle pulse per output bit; sets the bit rate |
| meas_data | input | 7 | Measurement value returned for `chan_addr` |
| chan_addr | output | 8 | Channel address of the current word slot |
| addr_valid | output | 1 | High when the current slot is a data slot |
| ser_out | output | 1 | Serial telemetry bit |
| minor_mark | output | 1 | High with the first bit of each minor frame |
| major_mark | output | 1 | High with the first bit of each major frame |

## Verification
The bench first runs two full major frames with a strobe on every cycle. This checks every bit of every word against an independent model. It also counts how often each address is served in the second frame, which separates a wrong deck size or base from a wrong slot map. A second run spaces the strobes irregularly, one to four cycles apart, so a design that moves without a strobe, or loses a bit after a gap, is caught. A reset in the middle of a frame shows that the framing and all deck positions restart from zero rather than carrying over.

// File: rtl/tlm_commutator_pkg.sv
package tlm_commutator_pkg;

    localparam int unsigned NUM_DECKS = 4;

    typedef enum logic [2:0] {
        SRC_SYNC  = 3'd0,
        SRC_DECK0 = 3'd1,
        SRC_DECK1 = 3'd2,
        SRC_DECK2 = 3'd3,
        SRC_DECK3 = 3'd4
    } slot_src_e;

    typedef struct packed {
        logic bit_val;
        logic minor_mark;
        logic major_mark;
    } line_out_t;

    // Fixed slot map: slot 0 sync, then the fast deck, then one slot per slower deck.
    function automatic slot_src_e slot_source(input int unsigned slot,
                                              input int unsigned frame_words);
        if (slot == 0)                     return SRC_SYNC;
        else if (slot < frame_words - 3)   return SRC_DECK0;
        else if (slot == frame_words - 3)  return SRC_DECK1;
        else if (slot == frame_words - 2)  return SRC_DECK2;
        else                               return SRC_DECK3;
    endfunction

    // Positions per deck, chosen so that each deck wraps together at the major frame.
    function automatic int unsigned deck_size(input int unsigned deck,
                                              input int unsigned frame_words,
                                              input int unsigned fast_rate,
                                              input int unsigned mid_rate,
                                              input int unsigned low_rate);
        case (deck)
            0:       return frame_words - 4;
            1:       return fast_rate / mid_rate;
            2:       return fast_rate / low_rate;
            default: return fast_rate;
        endcase
    endfunction

    function automatic int unsigned deck_base(input int unsigned deck,
                                              input int unsigned frame_words,
                                              input int unsigned fast_rate,
                                              input int unsigned mid_rate,
                                              input int unsigned low_rate);
        int unsigned acc;
        acc = 0;
        for (int unsigned d = 0; d < deck; d++)
            acc += deck_size(d, frame_words, fast_rate, mid_rate, low_rate);
        return acc;
    endfunction

endpackage

// File: rtl/tcm_frame_timer.sv
module tcm_frame_timer #(
    parameter int unsigned WORD_W      = 7,
    parameter int unsigned FRAME_WORDS = 32,
    parameter int unsigned MINORS      = 128,
    parameter int unsigned SLOT_W      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    output logic [SLOT_W-1:0] slot_o,
    output logic              word_first_o,
    output logic              word_last_o,
    output logic              major_end_o,
    output logic              sync_slot_o,
    output logic              major_head_o
);
    localparam int unsigned BIT_W   = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int unsigned MINOR_W = (MINORS > 1) ? $clog2(MINORS) : 1;

    logic [BIT_W-1:0]   bit_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [MINOR_W-1:0] minor_q;
    logic last_bit, last_slot, last_minor;

    assign last_bit   = (bit_q == BIT_W'(WORD_W - 1));
    assign last_slot  = (slot_q == SLOT_W'(FRAME_WORDS - 1));
    assign last_minor = (minor_q == MINOR_W'(MINORS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q   <= '0;
            slot_q  <= '0;
            minor_q <= '0;
        end else if (bit_stb) begin
            if (last_bit) begin
                bit_q <= '0;
                if (last_slot) begin
                    slot_q  <= '0;
                    minor_q <= last_minor ? '0 : minor_q + 1'b1;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    assign slot_o       = slot_q;
    assign word_first_o = (bit_q == '0);
    assign word_last_o  = last_bit;
    assign major_end_o  = last_bit && last_slot && last_minor;
    assign sync_slot_o  = (slot_q == '0);
    assign major_head_o = (slot_q == '0) && (minor_q == '0);
endmodule

// File: rtl/tcm_deck_sequencer.sv
module tcm_deck_sequencer
    import tlm_commutator_pkg::*;
#(
    parameter int unsigned FRAME_WORDS = 32,
    parameter int unsigned FAST_RATE   = 128,
    parameter int unsigned MID_RATE    = 16,
    parameter int unsigned LOW_RATE    = 2,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SLOT_W      = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          step_i,
    input  logic                          major_end_i,
    input  logic [SLOT_W-1:0]             slot_i,
    output logic [ADDR_W-1:0]             addr_o,
    output logic                          addr_valid_o,
    output logic [NUM_DECKS*ADDR_W-1:0]   pos_flat_o
);
    slot_src_e src;
    assign src = slot_source(32'(slot_i), FRAME_WORDS);

    for (genvar k = 0; k < NUM_DECKS; k++) begin : g_deck
        localparam int unsigned SIZE =
            deck_size(k, FRAME_WORDS, FAST_RATE, MID_RATE, LOW_RATE);
        logic [ADDR_W-1:0] pos_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                pos_q <= '0;
            end else if (step_i) begin
                if (major_end_i)
                    pos_q <= '0;
                else if (int'(src) == k + 1)
                    pos_q <= (pos_q == ADDR_W'(SIZE - 1)) ? '0 : pos_q + 1'b1;
            end
        end

        assign pos_flat_o[k*ADDR_W +: ADDR_W] = pos_q;
    end

    always_comb begin
        addr_o       = '0;
        addr_valid_o = 1'b0;
        for (int k = 0; k < NUM_DECKS; k++) begin
            if (int'(src) == k + 1) begin
                addr_o = ADDR_W'(deck_base(k, FRAME_WORDS, FAST_RATE, MID_RATE, LOW_RATE))
                         + pos_flat_o[k*ADDR_W +: ADDR_W];
                addr_valid_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tcm_word_serializer.sv
module tcm_word_serializer
    import tlm_commutator_pkg::*;
#(
    parameter int unsigned         WORD_W    = 7,
    parameter logic [WORD_W-1:0]   SYNC_WORD = WORD_W'(7'h72)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              word_first_i,
    input  logic              sync_slot_i,
    input  logic              major_head_i,
    input  logic [WORD_W-1:0] meas_i,
    output line_out_t         line_o
);
    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] load_word;
    line_out_t         line_q;

    assign load_word = sync_slot_i ? SYNC_WORD : meas_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            line_q  <= '0;
        end else if (bit_stb) begin
            if (word_first_i) begin
                line_q.bit_val    <= load_word[WORD_W-1];
                line_q.minor_mark <= sync_slot_i;
                line_q.major_mark <= major_head_i;
                shift_q           <= load_word << 1;
            end else begin
                line_q.bit_val    <= shift_q[WORD_W-1];
                line_q.minor_mark <= 1'b0;
                line_q.major_mark <= 1'b0;
                shift_q           <= shift_q << 1;
            end
        end
    end

    assign line_o = line_q;
endmodule

// File: rtl/tlm_commutator.sv
module tlm_commutator
    import tlm_commutator_pkg::*;
#(
    parameter int unsigned       WORD_W      = 7,
    parameter int unsigned       FRAME_WORDS = 32,
    parameter int unsigned       ADDR_W      = 8,
    parameter int unsigned       FAST_RATE   = 128,
    parameter int unsigned       MID_RATE    = 16,
    parameter int unsigned       LOW_RATE    = 2,
    parameter logic [WORD_W-1:0] SYNC_WORD   = WORD_W'(7'h72)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic [WORD_W-1:0] meas_data,
    output logic [ADDR_W-1:0] chan_addr,
    output logic              addr_valid,
    output logic              ser_out,
    output logic              minor_mark,
    output logic              major_mark
);
    localparam int unsigned SLOT_W     = $clog2(FRAME_WORDS);
    localparam int unsigned TOTAL_ADDR =
        deck_base(NUM_DECKS, FRAME_WORDS, FAST_RATE, MID_RATE, LOW_RATE);

    logic [SLOT_W-1:0]           slot;
    logic                        word_first, word_last, major_end;
    logic                        sync_slot, major_head;
    logic [NUM_DECKS*ADDR_W-1:0] pos_flat;
    line_out_t                   line;

    tcm_frame_timer #(
        .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS),
        .MINORS(FAST_RATE), .SLOT_W(SLOT_W)
    ) u_timer (
        .clk(clk), .rst(rst), .bit_stb(bit_stb),
        .slot_o(slot), .word_first_o(word_first), .word_last_o(word_last),
        .major_end_o(major_end), .sync_slot_o(sync_slot), .major_head_o(major_head)
    );

    tcm_deck_sequencer #(
        .FRAME_WORDS(FRAME_WORDS), .FAST_RATE(FAST_RATE), .MID_RATE(MID_RATE),
        .LOW_RATE(LOW_RATE), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
    ) u_decks (
        .clk(clk), .rst(rst),
        .step_i(bit_stb && word_last), .major_end_i(major_end),
        .slot_i(slot), .addr_o(chan_addr), .addr_valid_o(addr_valid),
        .pos_flat_o(pos_flat)
    );

    tcm_word_serializer #(
        .WORD_W(WORD_W), .SYNC_WORD(SYNC_WORD)
    ) u_ser (
        .clk(clk), .rst(rst), .bit_stb(bit_stb),
        .word_first_i(word_first), .sync_slot_i(sync_slot),
        .major_head_i(major_head), .meas_i(meas_data), .line_o(line)
    );

    assign ser_out    = line.bit_val;
    assign minor_mark = line.minor_mark;
    assign major_mark = line.major_mark;
endmodule

// File: rtl/tcm_checker.sv
module tcm_checker #(
    parameter int unsigned       WORD_W     = 7,
    parameter int unsigned       ADDR_W     = 8,
    parameter int unsigned       POS_W      = 32,
    parameter int unsigned       TOTAL_ADDR = 228,
    parameter logic [WORD_W-1:0] SYNC_WORD  = WORD_W'(7'h72)
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_stb,
    input logic              meas_msb,
    input logic [ADDR_W-1:0] chan_addr,
    input logic              addr_valid,
    input logic              ser_out,
    input logic              minor_mark,
    input logic              major_mark,
    input logic              word_first,
    input logic              major_end,
    input logic [POS_W-1:0]  pos_flat
);
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(ser_out) && $stable(minor_mark)
                     && $stable(major_mark) && $stable(chan_addr));

    assert_addr_range_R5: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> (32'(chan_addr) < TOTAL_ADDR));

    assert_first_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && word_first && addr_valid) |=> (ser_out == $past(meas_msb)));

    assert_sync_head_R3: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && word_first && !addr_valid) |=>
            (minor_mark && ser_out == SYNC_WORD[WORD_W-1]));

    assert_mark_nest_R8: assert property (@(posedge clk) disable iff (rst)
        major_mark |-> minor_mark);

    assert_major_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && major_end) |=> (pos_flat == '0));
endmodule

bind tlm_commutator tcm_checker #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .POS_W(NUM_DECKS*ADDR_W),
    .TOTAL_ADDR(TOTAL_ADDR), .SYNC_WORD(SYNC_WORD)
) chk_i (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .meas_msb(meas_data[WORD_W-1]),
    .chan_addr(chan_addr), .addr_valid(addr_valid), .ser_out(ser_out),
    .minor_mark(minor_mark), .major_mark(major_mark), .word_first(word_first),
    .major_end(major_end), .pos_flat(pos_flat)
);

// File: tb/tlm_commutator_tb.sv
module tlm_commutator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] SYNC = 7'b1110010;
    localparam int SIZE [4] = '{28, 8, 64, 128};
    localparam int BASE [4] = '{0, 28, 36, 100};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic [6:0] meas_data;
    logic [7:0] chan_addr;
    logic       addr_valid, ser_out, minor_mark, major_mark;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int e_bit, e_slot, e_minor, major_no;
    int e_pos [4];
    bit counting;
    int cnt [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [6:0] meas_of(input logic [7:0] a);
        return 7'((int'(a) * 37 + 11) % 128);
    endfunction

    always_comb meas_data = meas_of(chan_addr);

    tlm_commutator dut_i (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .meas_data(meas_data),
        .chan_addr(chan_addr), .addr_valid(addr_valid), .ser_out(ser_out),
        .minor_mark(minor_mark), .major_mark(major_mark)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int deck_of(input int slot);
        if (slot <= 28) return 0;
        return slot - 28;
    endfunction

    task automatic model_reset();
        e_bit = 0; e_slot = 0; e_minor = 0; major_no = 0;
        for (int d = 0; d < 4; d++) e_pos[d] = 0;
    endtask

    task automatic check_reset_state(input string when);
        check(ser_out == 1'b0,    "R1", {when, " ser_out"},    int'(ser_out), 0);
        check(minor_mark == 1'b0, "R1", {when, " minor_mark"}, int'(minor_mark), 0);
        check(major_mark == 1'b0, "R1", {when, " major_mark"}, int'(major_mark), 0);
        check(addr_valid == 1'b0, "R1", {when, " addr_valid"}, int'(addr_valid), 0);
        check(chan_addr == 8'd0,  "R1", {when, " chan_addr"},  int'(chan_addr), 0);
    endtask

    // One strobe, then `gap` idle cycles; called at a negedge.
    task automatic step(input int gap);
        bit         exp_valid;
        int         exp_addr;
        logic [6:0] exp_word;
        bit         exp_minor, exp_major;
        logic       h_ser, h_min, h_maj;
        logic [7:0] h_addr;
        exp_valid = (e_slot != 0);
        exp_addr  = exp_valid ? BASE[deck_of(e_slot)] + e_pos[deck_of(e_slot)] : 0;
        if (e_bit == 0) begin
            check(addr_valid == exp_valid, "R10", "addr_valid at word start",
                  int'(addr_valid), int'(exp_valid));
            if (exp_valid)
                check(int'(chan_addr) == exp_addr, "R5 R6", "chan_addr",
                      int'(chan_addr), exp_addr);
            if (counting && addr_valid) cnt[chan_addr]++;
        end
        exp_word  = exp_valid ? meas_of(8'(exp_addr)) : SYNC;
        exp_minor = (e_slot == 0) && (e_bit == 0);
        exp_major = exp_minor && (e_minor == 0);
        bit_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bit_stb = 1'b0;
        if (exp_valid)
            check(ser_out == exp_word[6 - e_bit], "R2", "data bit",
                  int'(ser_out), int'(exp_word[6 - e_bit]));
        else
            check(ser_out == exp_word[6 - e_bit], "R3", "sync bit",
                  int'(ser_out), int'(exp_word[6 - e_bit]));
        check(minor_mark == exp_minor, "R4", "minor_mark", int'(minor_mark), int'(exp_minor));
        check(major_mark == exp_major, "R8", "major_mark", int'(major_mark), int'(exp_major));
        // advance model
        if (e_bit == 6) begin
            if (e_slot != 0) begin
                int d = deck_of(e_slot);
                e_pos[d] = (e_pos[d] + 1) % SIZE[d];
            end
            e_bit = 0;
            e_slot++;
            if (e_slot == 32) begin
                e_slot = 0;
                e_minor++;
                if (e_minor == 128) begin
                    e_minor = 0;
                    major_no++;
                    for (int d = 0; d < 4; d++) e_pos[d] = 0;
                end
            end
        end else begin
            e_bit++;
        end
        if (gap > 0) begin
            h_ser = ser_out; h_min = minor_mark; h_maj = major_mark; h_addr = chan_addr;
            repeat (gap) @(negedge clk);
            check(ser_out == h_ser && minor_mark == h_min && major_mark == h_maj
                  && chan_addr == h_addr, "R9", "outputs held without strobe",
                  int'({ser_out, minor_mark, major_mark, chan_addr}),
                  int'({h_ser, h_min, h_maj, h_addr}));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) cnt[a] = 0;
        counting = 0;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_reset_state("during reset");
        rst = 1'b0;
        @(negedge clk);
        check_reset_state("after reset");

        // Phase A: two major frames, strobe every cycle; count addresses in the second.
        while (major_no < 2) begin
            counting = (major_no == 1);
            step(0);
        end
        counting = 0;
        for (int a = 0; a < 256; a++) begin
            int exp_n;
            if (a < 28)       exp_n = 128;
            else if (a < 36)  exp_n = 16;
            else if (a < 100) exp_n = 2;
            else if (a < 228) exp_n = 1;
            else              exp_n = 0;
            check(cnt[a] == exp_n, "R7", $sformatf("samples of address %0d", a),
                  cnt[a], exp_n);
        end

        // Phase B: irregular strobe spacing.
        for (int i = 0; i < 4000; i++) step(i % 4);

        // Mid-frame reset: framing and decks restart.
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_state("mid-frame reset");
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        check_reset_state("after mid-frame reset");
        for (int i = 0; i < 600; i++) step(i % 2);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule